// File: doc/BRIEF.md
# Circular-Buffer FIR MAC Engine

This block is a sequenced finite impulse response filter. Each sample that arrives on a valid/ready stream is written into a circular sample store. The engine then spends one cycle per tap on a multiply-accumulate. In each of those cycles it reads one stored sample and one coefficient, from two separate stores, in the same cycle. After the last tap it rounds the sum, saturates it to the data width and emits it as a one-cycle pulse on the output stream. A plain write port loads the coefficients.

The read pointer into the sample store wraps modulo the tap count. The coefficient index runs from zero to the last tap. After each pass the sample pointer moves back one place, so the next incoming sample overwrites the oldest one. The accumulator is twice the data width plus eight guard bits. Every pass clears it on the first tap and adds the rounding constant on the last tap.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every stored sample and every coefficient is zero. A first sample therefore sees an all-zero history.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 until the cycle in which the result is presented. A sample offered while in_ready is 0 is ignored and never enters the history.
- R3: out_valid rises exactly TAPS clock edges after the accepting edge and stays high for one cycle only. out_data changes only together with out_valid.
- R4: The result is the sum over i from 0 to TAPS-1 of coef[i] times s[i], where s[0] is the sample just taken and s[i] is the sample taken i acceptances earlier.
- R5: When coef_we is 1 at a clock edge, coef_wdata is stored as coef[coef_addr]. The new value is used by every later pass.
- R6: Samples and coefficients are signed two's-complement fractions with DATA_W-1 fraction bits. Each product is doubled before it is summed. The sum is held in 2*DATA_W+EXT_W bits.
- R7: The final tap adds 2^(DATA_W-1) to the sum. The output is the sum's bits [2*DATA_W-1:DATA_W], so an exact half LSB rounds upward.
- R8: If sum bits [2*DATA_W+EXT_W-1:2*DATA_W-1] are not all equal, the output is 0x7FFFFF for a positive sum and 0x800000 for a negative one. A single product of -1.0 by -1.0 saturates.
- R9: While out_valid is 1, in_ready is also 1. A sample offered in that cycle is accepted and starts the next pass with no idle cycle. A sample that is TAPS acceptances old no longer contributes, because its slot has been overwritten.
- R10: Each pass starts from a cleared accumulator. After a saturated pass, a pass with all-zero coefficients yields exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Coefficient index to write |
| coef_wdata | input | DATA_W | Coefficient value |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W | Rounded, saturated result |

## Verification
The function most likely to collide with another is emitting a result while accepting the next sample. Both happen in the same cycle, because ready returns high together with the result strobe. The bench provokes this by driving each new sample in the very cycle out_valid is seen. It then checks that the result is correct and that the next pass shows the same TAPS-cycle latency, with the pointer step-back and the new write landing in the correct slot. The bench also offers junk samples throughout a pass, and the next result shows whether any of them leaked into the history.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fir_state_e;
endpackage

// File: rtl/fir_sample_ring.sv
// Circular sample store: write at the head, read at head+offset modulo TAPS,
// head moves back one slot on request.
module fir_sample_ring #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      step_back,
    input  logic [$clog2(TAPS)-1:0]   rd_off,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int AW = $clog2(TAPS);
    localparam logic [AW:0]   TAPS_X = (AW+1)'(TAPS);
    localparam logic [AW-1:0] LAST   = AW'(TAPS - 1);

    logic [DATA_W-1:0] mem_q [TAPS];
    logic [AW-1:0]     head_d, head_q;
    logic [AW:0]       sum_raw;
    logic [AW:0]       sum_mod;

    always_comb begin
        head_d = head_q;
        if (step_back) begin
            head_d = (head_q == '0) ? LAST : head_q - AW'(1);
        end
    end

    always_comb begin
        sum_raw = {1'b0, head_q} + {1'b0, rd_off};
        sum_mod = (sum_raw >= TAPS_X) ? sum_raw - TAPS_X : sum_raw;
    end

    assign rd_data = mem_q[sum_mod[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            for (int i = 0; i < TAPS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            head_q <= head_d;
            if (wr_en) begin
                mem_q[head_q] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fir_coef_bank.sv
// Coefficient store with one write port and one read port.
module fir_coef_bank #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(TAPS)-1:0]   wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(TAPS)-1:0]   rd_idx,
    output logic [DATA_W-1:0]         rd_data
);
    logic [DATA_W-1:0] mem_q [TAPS];

    assign rd_data = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/fir_mac_datapath.sv
// One tap: doubled signed product into a guarded accumulator, optional clear
// and rounding, plus the saturated result view of the new sum.
module fir_mac_datapath #(
    parameter int DATA_W = 24,
    parameter int EXT_W  = 8
) (
    input  logic [DATA_W-1:0]            sample,
    input  logic [DATA_W-1:0]            coef,
    input  logic [2*DATA_W+EXT_W-1:0]    acc_in,
    input  logic                         clear,
    input  logic                         last,
    output logic [2*DATA_W+EXT_W-1:0]    acc_out,
    output logic [DATA_W-1:0]            result
);
    localparam int ACC_W = 2*DATA_W + EXT_W;
    localparam int HI    = 2*DATA_W - 1;
    localparam logic [ACC_W-1:0]  RND  =
        {{(ACC_W-DATA_W){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [2*DATA_W-1:0] prod;
    logic [ACC_W-1:0]           prod_x;
    logic [ACC_W-1:0]           base;
    logic [ACC_W-HI-1:0]        guard;
    logic                       in_range;

    always_comb begin
        prod     = $signed(sample) * $signed(coef);
        prod_x   = {{EXT_W{prod[2*DATA_W-1]}}, prod} << 1;
        base     = clear ? '0 : acc_in;
        acc_out  = base + prod_x + (last ? RND : '0);
        guard    = acc_out[ACC_W-1:HI];
        in_range = (guard == '0) || (guard == '1);
        if (in_range) begin
            result = acc_out[HI:DATA_W];
        end else begin
            result = acc_out[ACC_W-1] ? NEG_MAX : POS_MAX;
        end
    end
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 24,
    parameter int EXT_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      coef_we,
    input  logic [$clog2(TAPS)-1:0]   coef_addr,
    input  logic [DATA_W-1:0]         coef_wdata,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [DATA_W-1:0]         in_data,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data
);
    import fir_mac_pkg::*;

    localparam int AW    = $clog2(TAPS);
    localparam int ACC_W = 2*DATA_W + EXT_W;
    localparam logic [AW-1:0] LAST_TAP = AW'(TAPS - 1);

    typedef struct packed {
        fir_state_e        state;
        logic [AW-1:0]     tap;
        logic [ACC_W-1:0]  acc;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:     ST_IDLE,
        tap:       '0,
        acc:       '0,
        out_valid: 1'b0,
        out_data:  '0
    };

    ctl_t ctl_d, ctl_q;

    logic              accept;
    logic              last_tap;
    logic              running;
    logic [DATA_W-1:0] smp_rd;
    logic [DATA_W-1:0] cof_rd;
    logic [ACC_W-1:0]  mac_acc;
    logic [DATA_W-1:0] mac_result;

    assign running  = (ctl_q.state == ST_RUN);
    assign in_ready = !running;
    assign accept   = in_valid && in_ready;
    assign last_tap = (ctl_q.tap == LAST_TAP);

    fir_sample_ring #(
        .TAPS   (TAPS),
        .DATA_W (DATA_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_data   (in_data),
        .step_back (running && last_tap),
        .rd_off    (ctl_q.tap),
        .rd_data   (smp_rd)
    );

    fir_coef_bank #(
        .TAPS   (TAPS),
        .DATA_W (DATA_W)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_idx  (coef_addr),
        .wr_data (coef_wdata),
        .rd_idx  (ctl_q.tap),
        .rd_data (cof_rd)
    );

    fir_mac_datapath #(
        .DATA_W (DATA_W),
        .EXT_W  (EXT_W)
    ) u_mac (
        .sample  (smp_rd),
        .coef    (cof_rd),
        .acc_in  (ctl_q.acc),
        .clear   (ctl_q.tap == '0),
        .last    (last_tap),
        .acc_out (mac_acc),
        .result  (mac_result)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.out_valid = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state = ST_RUN;
                    ctl_d.tap   = '0;
                end
            end
            ST_RUN: begin
                ctl_d.acc = mac_acc;
                if (last_tap) begin
                    ctl_d.state     = ST_IDLE;
                    ctl_d.tap       = '0;
                    ctl_d.out_valid = 1'b1;
                    ctl_d.out_data  = mac_result;
                end else begin
                    ctl_d.tap = ctl_q.tap + AW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.out_valid;
    assign out_data  = ctl_q.out_data;
endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
    parameter int TAPS   = 8,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int CW = $clog2(TAPS + 2) + 1;

    logic [CW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (in_valid && in_ready) begin
            lat_q <= CW'(1);
        end else if (out_valid) begin
            lat_q <= '0;
        end else if (lat_q != '0) begin
            lat_q <= lat_q + CW'(1);
        end
    end

    AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_q == CW'(TAPS + 1)));  // R3

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);  // R3

    AST_DATA_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);  // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_q != '0) && !out_valid) |-> !in_ready);  // R2

    AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);  // R9
endmodule

bind fir_mac_engine fir_mac_engine_chk #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir_mac_engine_bench.sv
`timescale 1ns/1ps
module fir_mac_engine_bench;
    localparam int N  = 4;
    localparam int DW = 24;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_we = 1'b0;
    logic [AW-1:0] coef_addr = '0;
    logic [DW-1:0] coef_wdata = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int n_run  = 0;
    int n_fail = 0;
    longint hist [N];
    longint cmod [N];
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    fir_mac_engine #(.TAPS(N), .DATA_W(DW), .EXT_W(8)) u_fir_mac_engine (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_wdata(coef_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint sx(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint model_y();
        longint acc = 0;
        longint q;
        for (int i = 0; i < N; i++) acc += hist[i] * cmod[i] * 2;
        acc += 64'sd8388608;
        q = acc >>> 24;
        if (q > 64'sd8388607)  q = 64'sd8388607;
        if (q < -64'sd8388608) q = -64'sd8388608;
        return q;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_coef(input int idx, input longint val);
        coef_we = 1'b1; coef_addr = AW'(idx); coef_wdata = val[DW-1:0];
        @(negedge clk);
        coef_we = 1'b0;
        cmod[idx] = val;
    endtask

    // Offers a sample at the current falling edge and waits for its result.
    task automatic push(input longint val, input bit junk_en, input string req);
        longint exp;
        int     cnt = 0;
        bit     busy_ok = 1'b1;
        for (int i = N-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = val;
        exp = model_y();
        in_valid = 1'b1; in_data = val[DW-1:0];
        @(negedge clk);
        in_valid = 1'b0;
        if (junk_en) begin
            in_valid = 1'b1; in_data = 24'h5A5A5A;
        end
        while (!out_valid && cnt < 50) begin
            if (in_ready) busy_ok = 1'b0;
            @(negedge clk);
            cnt++;
        end
        in_valid = 1'b0;
        check(cnt == N, "R3 latency", cnt, N);
        check(busy_ok, "R2 ready low while busy", busy_ok, 1);
        check(in_ready == 1'b1, "R9 ready with result", in_ready, 1);
        check(sx(out_data) == exp, req, sx(out_data), exp);
    endtask

    task automatic flush();
        for (int i = 0; i < N; i++) push(0, 1'b0, "R4 flush");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin hist[i] = 0; cmod[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        check(out_data == '0, "R1 out_data after reset", sx(out_data), 0);

        // Coefficients, then a first sample against a zero history.
        set_coef(0, 64'sh100000);
        set_coef(1, 64'sh200000);
        set_coef(2, -64'sh080000);
        set_coef(3, 64'sh7FFFFF);
        push(64'sh400000, 1'b0, "R1 zero history");
        push(64'sh300000, 1'b0, "R5 coefficients applied");

        // Impulse walks through every tap, then falls out of the ring.
        flush();
        push(64'sh7FFFFF, 1'b0, "R4 impulse tap0");
        for (int k = 1; k < N; k++) push(0, 1'b0, "R4 impulse tap");
        push(0, 1'b0, "R9 oldest overwritten");

        // Back-to-back random sweep with junk offered while busy.
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < N; i++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                set_coef(i, sx(seed[30:7]));
            end
            for (int k = 0; k < 12; k++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                push(sx(seed[29:6]), (k % 3) == 1, "R6 random sum");
            end
        end
        push(-64'sd5, 1'b1, "R2 junk ignored");

        // Rounding at the half LSB.
        set_coef(0, 64'sh400000);
        for (int i = 1; i < N; i++) set_coef(i, 0);
        flush();
        push(1, 1'b0, "R7 half rounds up");
        check(out_data == 24'h000001, "R7 exact value", sx(out_data), 1);
        push(-1, 1'b0, "R7 negative half");
        check(out_data == 24'h000000, "R7 exact zero", sx(out_data), 0);
        push(3, 1'b0, "R7 three halves");

        // Saturation.
        for (int i = 0; i < N; i++) set_coef(i, 64'sh7FFFFF);
        for (int i = 0; i < N; i++) push(64'sh7FFFFF, 1'b0, "R8 positive");
        check(out_data == 24'h7FFFFF, "R8 positive clamp", sx(out_data), 64'sh7FFFFF);
        for (int i = 0; i < N; i++) push(-64'sh800000, 1'b0, "R8 negative");
        check(out_data == 24'h800000, "R8 negative clamp", sx(out_data), -64'sh800000);
        set_coef(0, -64'sh800000);
        for (int i = 1; i < N; i++) set_coef(i, 0);
        push(-64'sh800000, 1'b0, "R8 minus one squared");
        check(out_data == 24'h7FFFFF, "R8 minus one squared clamp", sx(out_data), 64'sh7FFFFF);

        // Accumulator cleared between passes.
        for (int i = 0; i < N; i++) set_coef(i, 64'sh7FFFFF);
        push(64'sh7FFFFF, 1'b0, "R8 saturate again");
        for (int i = 0; i < N; i++) set_coef(i, 0);
        push(64'sh7FFFFF, 1'b0, "R10 cleared accumulator");
        check(out_data == '0, "R10 exact zero", sx(out_data), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule